// File: doc/BRIEF.md
# Set-Associative Cache Tag Directory

This block is the bookkeeping half of a single-level, N-way set-associative cache with write-back and least-recently-used replacement. It stores no line data. For every memory reference it keeps the per-line tag, valid and dirty state and the per-set recency order, and it decides hit or miss. It also keeps running statistics from which overall, read and write miss rates and the memory traffic in both directions can be derived. Line size, total capacity and associativity are elaboration parameters, all powers of two, and the capacity must give at least two sets.

A reference is a 32-bit physical address plus an access kind, offered on a valid/ready handshake. After reset a two-state controller first walks every set and invalidates it (state CLEAR), then moves to RUN with the CLEAR→RUN transition taken when the last set has been cleared. In RUN it accepts one reference every cycle and returns a registered response one cycle later. The same state machine has no other transitions; reset always returns it to CLEAR.

Top module: `cdir_top`

## Requirements
- R1: While reset is high and for the SETS cycles after it (one set cleared per cycle), `req_ready` is low. Requests offered during that time are not accepted and no counter moves. Once `req_ready` rises every counter reads zero and every line is invalid.
- R2: The address splits into a line offset in the low log2(LINE_BYTES) bits, a set index in the next log2(SETS) bits, and the tag in the remaining upper bits. References that differ only in offset bits hit the same line.
- R3: In RUN, `req_ready` is high every cycle. A reference accepted at a clock edge produces `rsp_valid` high for exactly the following cycle, with `rsp_hit` and `rsp_addr` echoing the accepted address.
- R4: On a miss the victim is the lowest-numbered invalid way of the set; if all ways are valid it is the least recently used way. The recency order is updated on hits and on fills.
- R5: A write marks its line dirty on a hit and on a miss. A read or fetch miss fills a clean line. Evicting a valid dirty line raises `rsp_wb` with the response and adds one to `cnt_wb`. Evicting a clean line does neither.
- R6: `req_kind` encoding: 2'b01 is a write. 2'b00 is a read and 2'b10 is an instruction fetch, and both behave identically as reads (2'b11 is also taken as a read).
- R7: The counters `cnt_access`, `cnt_hit`, `cnt_miss`, `cnt_read`, `cnt_write`, `cnt_read_miss` and `cnt_write_miss` each add one per matching accepted reference. Hits plus misses always equal accesses.
- R8: `bytes_fetched` grows by LINE_BYTES on every miss, and `bytes_wb` grows by LINE_BYTES on every dirty eviction.
- R9: Repeating one address N times from a cold set gives one miss followed by N-1 hits.
- R10: In a direct-mapped configuration (WAYS = 1), two addresses with equal index and different tags, alternated, miss on every access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Reference offered |
| req_ready | output | 1 | Block can accept a reference (RUN state) |
| req_addr | input | 32 | Physical address of the reference |
| req_kind | input | 2 | 00 read, 01 write, 10 instruction fetch |
| rsp_valid | output | 1 | Response for the reference accepted on the previous edge |
| rsp_hit | output | 1 | That reference hit |
| rsp_wb | output | 1 | That reference evicted a dirty line |
| rsp_addr | output | 32 | Address of that reference |
| cnt_access | output | CNT_W | Accepted references |
| cnt_hit | output | CNT_W | Hits |
| cnt_miss | output | CNT_W | Misses |
| cnt_read | output | CNT_W | Reads and fetches |
| cnt_write | output | CNT_W | Writes |
| cnt_read_miss | output | CNT_W | Read and fetch misses |
| cnt_write_miss | output | CNT_W | Write misses |
| cnt_wb | output | CNT_W | Dirty evictions |
| bytes_fetched | output | CNT_W | Bytes brought in from memory |
| bytes_wb | output | CNT_W | Bytes written back to memory |

## Verification
Every result of an accepted reference, the response flags and all counters, is registered at the edge that accepts it and is due one cycle later. The bench drives each reference at a falling edge, lets exactly one rising edge pass, and reads the response at the next falling edge, where the counters have already moved. The ready signal is due SETS cycles after reset is released, so the bench samples it low at the falling edge after the last clearing edge but one and high at the next. Totals are compared once the stimulus ends, against sums taken over the stimulus table.

// File: rtl/cdir_pkg.sv
package cdir_pkg;

    // Access kind carried on req_kind
    typedef enum logic [1:0] {
        ACC_READ  = 2'b00,
        ACC_WRITE = 2'b01,
        ACC_FETCH = 2'b10,
        ACC_RSVD  = 2'b11
    } acc_kind_e;

    // Controller states: invalidate sets, then serve references
    typedef enum logic {
        ST_CLEAR = 1'b0,
        ST_RUN   = 1'b1
    } dir_state_e;

endpackage

// File: rtl/cdir_way_select.sv
// Compares the request tag against one set and picks the way to use.
module cdir_way_select #(
    parameter int WAYS  = 4,
    parameter int TAG_W = 24,
    parameter int AGE_W = 2
) (
    input  logic [WAYS-1:0]             set_valid,
    input  logic [WAYS-1:0][TAG_W-1:0]  set_tag,
    input  logic [WAYS-1:0][AGE_W-1:0]  set_age,
    input  logic [TAG_W-1:0]            look_tag,
    output logic                        hit,
    output logic [AGE_W-1:0]            hit_way,
    output logic [AGE_W-1:0]            victim_way
);
    localparam logic [AGE_W-1:0] OLDEST = AGE_W'(WAYS - 1);

    logic              any_free;
    logic [AGE_W-1:0]  free_way;
    logic [AGE_W-1:0]  lru_way;

    always_comb begin
        hit     = 1'b0;
        hit_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (set_valid[w] && (set_tag[w] == look_tag)) begin
                hit     = 1'b1;
                hit_way = AGE_W'(w);
            end
        end
    end

    // Lowest-numbered invalid way wins: scan downward, last match kept
    always_comb begin
        any_free = 1'b0;
        free_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!set_valid[w]) begin
                any_free = 1'b1;
                free_way = AGE_W'(w);
            end
        end
    end

    always_comb begin
        lru_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (set_age[w] == OLDEST) begin
                lru_way = AGE_W'(w);
            end
        end
    end

    assign victim_way = any_free ? free_way : lru_way;

endmodule

// File: rtl/cdir_lru_age.sv
// Age update: touched way becomes 0, younger ways age by one.
module cdir_lru_age #(
    parameter int WAYS  = 4,
    parameter int AGE_W = 2
) (
    input  logic [WAYS-1:0][AGE_W-1:0] age_in,
    input  logic [AGE_W-1:0]           touch_way,
    output logic [WAYS-1:0][AGE_W-1:0] age_out
);
    logic [AGE_W-1:0] touched_age;

    always_comb begin
        touched_age = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (AGE_W'(w) == touch_way) begin
                touched_age = age_in[w];
            end
        end
    end

    generate
        for (genvar g = 0; g < WAYS; g++) begin : g_age
            always_comb begin
                if (AGE_W'(g) == touch_way) begin
                    age_out[g] = '0;
                end else if (age_in[g] < touched_age) begin
                    age_out[g] = age_in[g] + AGE_W'(1);
                end else begin
                    age_out[g] = age_in[g];
                end
            end
        end
    endgenerate

endmodule

// File: rtl/cdir_stats.sv
// Running statistics for accepted references.
module cdir_stats #(
    parameter int LINE_BYTES = 32,
    parameter int CNT_W      = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fire,
    input  logic             hit,
    input  logic             is_write,
    input  logic             evict_dirty,
    output logic [CNT_W-1:0] cnt_access,
    output logic [CNT_W-1:0] cnt_hit,
    output logic [CNT_W-1:0] cnt_miss,
    output logic [CNT_W-1:0] cnt_read,
    output logic [CNT_W-1:0] cnt_write,
    output logic [CNT_W-1:0] cnt_read_miss,
    output logic [CNT_W-1:0] cnt_write_miss,
    output logic [CNT_W-1:0] cnt_wb,
    output logic [CNT_W-1:0] bytes_fetched,
    output logic [CNT_W-1:0] bytes_wb
);
    localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
    localparam logic [CNT_W-1:0] LINE = CNT_W'(LINE_BYTES);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_access     <= '0;
            cnt_hit        <= '0;
            cnt_miss       <= '0;
            cnt_read       <= '0;
            cnt_write      <= '0;
            cnt_read_miss  <= '0;
            cnt_write_miss <= '0;
            cnt_wb         <= '0;
            bytes_fetched  <= '0;
            bytes_wb       <= '0;
        end else if (fire) begin
            cnt_access <= cnt_access + ONE;
            if (is_write) begin
                cnt_write <= cnt_write + ONE;
            end else begin
                cnt_read <= cnt_read + ONE;
            end
            if (hit) begin
                cnt_hit <= cnt_hit + ONE;
            end else begin
                cnt_miss      <= cnt_miss + ONE;
                bytes_fetched <= bytes_fetched + LINE;
                if (is_write) begin
                    cnt_write_miss <= cnt_write_miss + ONE;
                end else begin
                    cnt_read_miss <= cnt_read_miss + ONE;
                end
            end
            if (evict_dirty) begin
                cnt_wb   <= cnt_wb + ONE;
                bytes_wb <= bytes_wb + LINE;
            end
        end
    end

endmodule

// File: rtl/cdir_top.sv
module cdir_top
    import cdir_pkg::*;
#(
    parameter int LINE_BYTES  = 32,
    parameter int CACHE_BYTES = 1024,
    parameter int WAYS        = 4,
    parameter int CNT_W       = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [31:0]      req_addr,
    input  logic [1:0]       req_kind,
    output logic             rsp_valid,
    output logic             rsp_hit,
    output logic             rsp_wb,
    output logic [31:0]      rsp_addr,
    output logic [CNT_W-1:0] cnt_access,
    output logic [CNT_W-1:0] cnt_hit,
    output logic [CNT_W-1:0] cnt_miss,
    output logic [CNT_W-1:0] cnt_read,
    output logic [CNT_W-1:0] cnt_write,
    output logic [CNT_W-1:0] cnt_read_miss,
    output logic [CNT_W-1:0] cnt_write_miss,
    output logic [CNT_W-1:0] cnt_wb,
    output logic [CNT_W-1:0] bytes_fetched,
    output logic [CNT_W-1:0] bytes_wb
);
    localparam int ADDR_W = 32;
    localparam int SETS   = CACHE_BYTES / (LINE_BYTES * WAYS);
    localparam int OFF_W  = $clog2(LINE_BYTES);
    localparam int IDX_W  = $clog2(SETS);
    localparam int TAG_W  = ADDR_W - OFF_W - IDX_W;
    localparam int AGE_W  = (WAYS > 1) ? $clog2(WAYS) : 1;
    localparam logic [IDX_W-1:0] LAST_SET = IDX_W'(SETS - 1);

    // Controller
    dir_state_e       state_q, state_d;
    logic [IDX_W-1:0] clr_idx_q;
    logic             clr_last;
    logic             accept;

    // Directory storage
    logic [SETS-1:0][WAYS-1:0]             valid_q;
    logic [SETS-1:0][WAYS-1:0]             dirty_q;
    logic [SETS-1:0][WAYS-1:0][TAG_W-1:0]  tag_q;
    logic [SETS-1:0][WAYS-1:0][AGE_W-1:0]  age_q;

    // Lookup path
    logic [IDX_W-1:0]            set_idx;
    logic [TAG_W-1:0]            look_tag;
    logic                        is_write;
    logic                        hit;
    logic [AGE_W-1:0]            hit_way;
    logic [AGE_W-1:0]            victim_way;
    logic [AGE_W-1:0]            use_way;
    logic                        evict_dirty;
    logic [WAYS-1:0][AGE_W-1:0]  age_next;

    assign set_idx  = req_addr[OFF_W +: IDX_W];
    assign look_tag = req_addr[ADDR_W-1 -: TAG_W];
    assign is_write = (acc_kind_e'(req_kind) == ACC_WRITE);

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_CLEAR;
            clr_idx_q <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_CLEAR) begin
                clr_idx_q <= clr_idx_q + IDX_W'(1);
            end
        end
    end

    // Next state and controller outputs
    always_comb begin
        clr_last  = (clr_idx_q == LAST_SET);
        state_d   = state_q;
        req_ready = 1'b0;
        unique case (state_q)
            ST_CLEAR: begin
                if (clr_last) begin
                    state_d = ST_RUN;
                end
            end
            ST_RUN: begin
                req_ready = 1'b1;
            end
        endcase
    end

    assign accept = req_valid && req_ready;

    cdir_way_select #(
        .WAYS  (WAYS),
        .TAG_W (TAG_W),
        .AGE_W (AGE_W)
    ) u_sel (
        .set_valid  (valid_q[set_idx]),
        .set_tag    (tag_q[set_idx]),
        .set_age    (age_q[set_idx]),
        .look_tag   (look_tag),
        .hit        (hit),
        .hit_way    (hit_way),
        .victim_way (victim_way)
    );

    assign use_way     = hit ? hit_way : victim_way;
    assign evict_dirty = !hit && valid_q[set_idx][victim_way] && dirty_q[set_idx][victim_way];

    cdir_lru_age #(
        .WAYS  (WAYS),
        .AGE_W (AGE_W)
    ) u_age (
        .age_in    (age_q[set_idx]),
        .touch_way (use_way),
        .age_out   (age_next)
    );

    // Directory update: clearing walk, then one reference per cycle
    always_ff @(posedge clk) begin
        if (!rst) begin
            if (state_q == ST_CLEAR) begin
                valid_q[clr_idx_q] <= '0;
                dirty_q[clr_idx_q] <= '0;
                for (int w = 0; w < WAYS; w++) begin
                    age_q[clr_idx_q][w] <= AGE_W'(w);
                end
            end else if (accept) begin
                valid_q[set_idx][use_way] <= 1'b1;
                tag_q[set_idx][use_way]   <= look_tag;
                age_q[set_idx]            <= age_next;
                if (is_write) begin
                    dirty_q[set_idx][use_way] <= 1'b1;
                end else if (!hit) begin
                    dirty_q[set_idx][use_way] <= 1'b0;
                end
            end
        end
    end

    // Registered response
    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_wb    <= 1'b0;
            rsp_addr  <= '0;
        end else begin
            rsp_valid <= accept;
            if (accept) begin
                rsp_hit  <= hit;
                rsp_wb   <= evict_dirty;
                rsp_addr <= req_addr;
            end
        end
    end

    cdir_stats #(
        .LINE_BYTES (LINE_BYTES),
        .CNT_W      (CNT_W)
    ) u_stats (
        .clk            (clk),
        .rst            (rst),
        .fire           (accept),
        .hit            (hit),
        .is_write       (is_write),
        .evict_dirty    (evict_dirty),
        .cnt_access     (cnt_access),
        .cnt_hit        (cnt_hit),
        .cnt_miss       (cnt_miss),
        .cnt_read       (cnt_read),
        .cnt_write      (cnt_write),
        .cnt_read_miss  (cnt_read_miss),
        .cnt_write_miss (cnt_write_miss),
        .cnt_wb         (cnt_wb),
        .bytes_fetched  (bytes_fetched),
        .bytes_wb       (bytes_wb)
    );

endmodule

// File: rtl/cdir_checker.sv
module cdir_checker #(
    parameter int LINE_BYTES = 32,
    parameter int CNT_W      = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             req_valid,
    input logic             req_ready,
    input logic             rsp_valid,
    input logic             rsp_hit,
    input logic             rsp_wb,
    input logic [CNT_W-1:0] cnt_access,
    input logic [CNT_W-1:0] cnt_hit,
    input logic [CNT_W-1:0] cnt_miss,
    input logic [CNT_W-1:0] cnt_read,
    input logic [CNT_W-1:0] cnt_write,
    input logic [CNT_W-1:0] cnt_wb,
    input logic [CNT_W-1:0] bytes_fetched,
    input logic [CNT_W-1:0] bytes_wb
);
    localparam logic [CNT_W-1:0] LINE = CNT_W'(LINE_BYTES);

    assert_no_accept_when_busy_R1: assert property (@(posedge clk) disable iff (rst)
        !req_ready |=> $stable(cnt_access));

    assert_rsp_follows_accept_R3: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> rsp_valid);

    assert_no_rsp_without_accept_R3: assert property (@(posedge clk) disable iff (rst)
        !(req_valid && req_ready) |=> !rsp_valid);

    assert_wb_only_on_miss_R5: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_wb) |-> !rsp_hit);

    assert_wb_counted_R5: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_wb) |-> (cnt_wb == $past(cnt_wb) + CNT_W'(1)));

    assert_hit_miss_sum_R7: assert property (@(posedge clk) disable iff (rst)
        (cnt_hit + cnt_miss) == cnt_access);

    assert_read_write_sum_R7: assert property (@(posedge clk) disable iff (rst)
        (cnt_read + cnt_write) == cnt_access);

    assert_fetch_bytes_R8: assert property (@(posedge clk) disable iff (rst)
        bytes_fetched == cnt_miss * LINE);

    assert_wb_bytes_R8: assert property (@(posedge clk) disable iff (rst)
        bytes_wb == cnt_wb * LINE);

endmodule

bind cdir_top cdir_checker #(
    .LINE_BYTES (LINE_BYTES),
    .CNT_W      (CNT_W)
) u_chk (.*);

// File: tb/sim_cdir_top.sv
module sim_cdir_top;

    localparam int LINE  = 32;
    localparam int SIZE  = 1024;
    localparam int WAYS  = 4;
    localparam int SETS  = SIZE / (LINE * WAYS);
    localparam int SETS1 = SIZE / LINE;
    localparam int CW    = 32;
    localparam int NVEC  = 15;
    localparam int NREP  = 20;

    // Entry: [35:34] kind, [33:2] address, [1] expected hit, [0] expected dirty eviction
    // Set 0 uses tags 1..6 (address = tag << 8); 4 ways, 32-byte lines, 8 sets
    localparam logic [35:0] VEC [NVEC] = '{
        {2'b00, 32'h0000_0100, 1'b0, 1'b0},  // A miss, fills way 0
        {2'b00, 32'h0000_011F, 1'b1, 1'b0},  // A other offset: hit (R2)
        {2'b01, 32'h0000_0200, 1'b0, 1'b0},  // B write miss, dirty
        {2'b10, 32'h0000_0300, 1'b0, 1'b0},  // C fetch miss, clean
        {2'b00, 32'h0000_0400, 1'b0, 1'b0},  // D miss, set full
        {2'b00, 32'h0000_0100, 1'b1, 1'b0},  // A hit refreshes A
        {2'b00, 32'h0000_0500, 1'b0, 1'b1},  // E evicts LRU B (dirty)
        {2'b00, 32'h0000_0200, 1'b0, 1'b0},  // B evicts C (clean, fetched)
        {2'b01, 32'h0000_0100, 1'b1, 1'b0},  // A write hit -> dirty
        {2'b00, 32'h0000_0300, 1'b0, 1'b0},  // C evicts D (clean)
        {2'b00, 32'h0000_0500, 1'b1, 1'b0},  // E hit
        {2'b00, 32'h0000_0400, 1'b0, 1'b0},  // D evicts B (clean read fill)
        {2'b00, 32'h0000_0600, 1'b0, 1'b1},  // F evicts A (dirty by write hit)
        {2'b00, 32'h0000_0120, 1'b0, 1'b0},  // set 1 miss
        {2'b01, 32'h0000_0120, 1'b1, 1'b0}   // set 1 write hit
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [31:0]   req_addr = '0;
    logic [1:0]    req_kind = '0;
    logic          rsp_valid, rsp_hit, rsp_wb;
    logic [31:0]   rsp_addr;
    logic [CW-1:0] c_acc, c_hit, c_miss, c_rd, c_wr, c_rdm, c_wrm, c_wb, c_bf, c_bw;

    logic          v1 = 1'b0;
    logic          r1;
    logic [31:0]   a1 = '0;
    logic          rv1, rh1, rw1;
    logic [31:0]   ra1;
    logic [CW-1:0] d_acc, d_hit, d_miss, d_rd, d_wr, d_rdm, d_wrm, d_wb, d_bf, d_bw;

    cdir_top #(.LINE_BYTES(LINE), .CACHE_BYTES(SIZE), .WAYS(WAYS), .CNT_W(CW)) u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_kind(req_kind), .rsp_valid(rsp_valid),
        .rsp_hit(rsp_hit), .rsp_wb(rsp_wb), .rsp_addr(rsp_addr),
        .cnt_access(c_acc), .cnt_hit(c_hit), .cnt_miss(c_miss), .cnt_read(c_rd),
        .cnt_write(c_wr), .cnt_read_miss(c_rdm), .cnt_write_miss(c_wrm),
        .cnt_wb(c_wb), .bytes_fetched(c_bf), .bytes_wb(c_bw));

    cdir_top #(.LINE_BYTES(LINE), .CACHE_BYTES(SIZE), .WAYS(1), .CNT_W(CW)) u1 (
        .clk(clk), .rst(rst), .req_valid(v1), .req_ready(r1),
        .req_addr(a1), .req_kind(2'b00), .rsp_valid(rv1),
        .rsp_hit(rh1), .rsp_wb(rw1), .rsp_addr(ra1),
        .cnt_access(d_acc), .cnt_hit(d_hit), .cnt_miss(d_miss), .cnt_read(d_rd),
        .cnt_write(d_wr), .cnt_read_miss(d_rdm), .cnt_write_miss(d_wrm),
        .cnt_wb(d_wb), .bytes_fetched(d_bf), .bytes_wb(d_bw));

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    task automatic check(input string req, input string what, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Drive at a falling edge, one rising edge, sample at the next falling edge
    task automatic issue(input logic [1:0] k, input logic [31:0] a);
        @(negedge clk);
        req_valid = 1'b1;
        req_kind  = k;
        req_addr  = a;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : main
        int e_acc, e_hit, e_rd, e_wr, e_rdm, e_wrm, e_wb;
        e_acc = 0; e_hit = 0; e_rd = 0; e_wr = 0; e_rdm = 0; e_wrm = 0; e_wb = 0;

        // R1: requests offered during reset and clearing must be ignored
        req_valid = 1'b1;
        req_addr  = 32'h0000_0100;
        v1        = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        for (int k = 1; k <= SETS; k++) begin
            @(negedge clk);
            if (k == 4) begin
                req_valid = 1'b0;
                v1        = 1'b0;
            end
            if (k == SETS - 1) check("R1", "ready one cycle before clear done", longint'(req_ready), 0);
        end
        check("R1", "ready after SETS clearing cycles", longint'(req_ready), 1);
        check("R1", "accesses after clearing", longint'(c_acc), 0);
        check("R1", "misses after clearing", longint'(c_miss), 0);
        check("R1", "writebacks after clearing", longint'(c_wb), 0);
        check("R1", "no response while clearing", longint'(rsp_valid), 0);

        // Table walk: hits, LRU victims, dirty evictions, fetch as read
        for (int i = 0; i < NVEC; i++) begin
            logic [1:0]  k;
            logic [31:0] a;
            k = VEC[i][35:34];
            a = VEC[i][33:2];
            issue(k, a);
            check("R3", $sformatf("vec %0d rsp_valid", i), longint'(rsp_valid), 1);
            check("R3", $sformatf("vec %0d rsp_addr", i), longint'(rsp_addr), longint'(a));
            check("R4", $sformatf("vec %0d hit", i), longint'(rsp_hit), longint'(VEC[i][1]));
            check("R5", $sformatf("vec %0d dirty eviction", i), longint'(rsp_wb), longint'(VEC[i][0]));
            check("R3", $sformatf("vec %0d ready held", i), longint'(req_ready), 1);
            e_acc++;
            if (VEC[i][1]) e_hit++;
            if (k == 2'b01) begin
                e_wr++;
                if (!VEC[i][1]) e_wrm++;
            end else begin
                e_rd++;
                if (!VEC[i][1]) e_rdm++;
            end
            if (VEC[i][0]) e_wb++;
        end
        @(negedge clk);
        check("R3", "response lasts one cycle", longint'(rsp_valid), 0);

        // R9: one address repeated from a cold set (index 2), offsets varied (R2)
        for (int i = 0; i < NREP; i++) begin
            issue(2'b10, 32'h0000_0040 + 32'(i % LINE));
            check("R9", $sformatf("repeat %0d hit", i), longint'(rsp_hit), (i == 0) ? 0 : 1);
            e_acc++;
            e_rd++;
            if (i == 0) e_rdm++; else e_hit++;
        end

        // R7, R8, R6: totals against sums over the stimulus
        check("R7", "accesses", longint'(c_acc), e_acc);
        check("R7", "hits", longint'(c_hit), e_hit);
        check("R7", "misses", longint'(c_miss), e_acc - e_hit);
        check("R6", "reads incl fetches", longint'(c_rd), e_rd);
        check("R7", "writes", longint'(c_wr), e_wr);
        check("R6", "read misses", longint'(c_rdm), e_rdm);
        check("R7", "write misses", longint'(c_wrm), e_wrm);
        check("R5", "writebacks", longint'(c_wb), e_wb);
        check("R8", "bytes fetched", longint'(c_bf), longint'(e_acc - e_hit) * LINE);
        check("R8", "bytes written back", longint'(c_bw), longint'(e_wb) * LINE);

        // R10: direct-mapped instance, same index, alternating tags
        check("R1", "direct-mapped ready", longint'(r1), 1);
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            v1 = 1'b1;
            a1 = (i % 2 == 0) ? 32'h0000_0000 : 32'h0000_0400;
            @(negedge clk);
            v1 = 1'b0;
            check("R10", $sformatf("alternate %0d miss", i), longint'(rh1), 0);
        end
        check("R10", "direct-mapped misses", longint'(d_miss), 8);
        check("R10", "direct-mapped hits", longint'(d_hit), 0);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule